// File: doc/BRIEF.md
# Per-Pixel Programmable Shader Unit

This block produces a 640x480, 60 Hz video signal without any frame storage. The screen is divided into a grid of 64x48 logical pixels, each covering a 10x10 block of screen pixels. For every logical pixel a ten-instruction program runs, one instruction per pixel clock. It runs during the ten clocks in which the preceding logical pixel is on screen. The colour it sets is then shown for the whole 10-pixel span that follows.

The program sees the logical column, the logical row and a frame counter through read-only registers. It works with an 8-bit accumulator and eight scratch registers. A host replaces the program over a write-only SPI link. Bytes arrive in a shadow copy, and the shadow becomes the running program only during the last line of a frame. A frame is therefore never drawn with a mix of two programs.

All timing figures are parameters. The defaults give the standard 640x480 mode at a 25 MHz pixel clock: 800 clocks per line, 525 lines per frame, and negative-polarity syncs.

Top module: `pixel_shader_unit`

## Requirements
- R1: `hsync_n` is low exactly for line positions H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1, counted from 0 at the first visible pixel, and is high otherwise.
- R2: `vsync_n` is low exactly for lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1 and changes only at line position 0.
- R3: `rgb` is 0 whenever the position is outside the 640-wide, 480-tall visible area.
- R4: Within the visible area, `rgb` is constant over each CELL x CELL block. Its value is the result of the program for that block's logical column (position/CELL) and row (line/CELL).
- R5: An instruction byte is opcode[7:4] and argument[3:0], executed in byte order 0..9. The opcodes are:
  - 0: A=arg
  - 1: A=reg[arg]
  - 2: reg[arg]=A
  - 3: A+=reg
  - 4: A-=reg
  - 5: A&=reg
  - 6: A|=reg
  - 7: A^=reg
  - 8: A<<=arg
  - 9: A>>=arg
  - 10: colour=A[5:0]
  - 11: A+=arg
  - 12 to 15: no operation

  All arithmetic is 8-bit modulo 256.
- R6: Register indexes 0 to 7 are scratch registers. Index 8 reads the logical column, 9 the logical row and 10 the frame count modulo 256. Indexes 11 to 15 read 0. Writes to indexes 8 to 15 have no effect.
- R7: At the start of every logical pixel, the accumulator, the colour and all scratch registers are 0. When opcode 10 occurs more than once, the last occurrence sets the colour.
- R8: SPI works in mode 0, MSB first. Each complete byte received while `spi_cs_n` is low goes to the next program slot, starting from slot 0 at each assertion. Slots that are not sent keep their previous contents.
- R9: Bytes after the tenth in one transfer are ignored. So is an unfinished byte at the moment `spi_cs_n` rises.
- R10: A finished transfer takes effect from the first pixel of the next frame. Pixels of the frame in progress keep using the old program.
- R11: After reset, both syncs are high, `rgb` is 0 and every program slot holds 0x00, so the screen is black until a program is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_mosi | input | 1 | SPI data from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 6 | Colour as rrggbb, 0 during blanking |

## Verification
The hardest case to reach from the ports is the program change at the frame boundary. It interacts with shadow slots filled only in part, with transfers that send too many bytes, and with a transfer cut off in the middle of a byte.

The bench starts each transfer at the first pixel of a chosen frame. It keeps its own shadow and running copies of the program and swaps them at the frame boundary. It then compares every pixel of every frame against a model computed from the pixel's column, row and frame number. This makes a swap one frame early or late, a stray write past slot 9, or a half byte that is kept visible as wrong colours.

// File: rtl/shader_pkg.sv
// Shared constants and the instruction encoding of the pixel shader.
// Assumes an 8-bit datapath and a 6-bit rrggbb colour.
package shader_pkg;
    localparam int DW    = 8;   // datapath width
    localparam int CW    = 6;   // colour width
    localparam int NGPR  = 8;   // scratch registers
    localparam int REG_X = 8;   // read-only logical column
    localparam int REG_Y = 9;   // read-only logical row
    localparam int REG_F = 10;  // read-only frame count

    typedef enum logic [3:0] {
        OP_LDI  = 4'd0,
        OP_LD   = 4'd1,
        OP_ST   = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_COL  = 4'd10,
        OP_ADDI = 4'd11
    } op_e;
endpackage

// File: rtl/shader_timing.sv
// Raster timing for the shader: line/frame counters, syncs, the step
// within the current cell, and the coordinates of the cell being
// computed (the one displayed next). Assumes the line length is a
// multiple of CELL and that at least one blank line ends each frame.
module shader_timing #(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int CELL   = 10,
    localparam int DW    = shader_pkg::DW,
    localparam int SW    = $clog2(CELL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] step_o,
    output logic          step_last_o,
    output logic          vis_now_o,
    output logic          vis_next_o,
    output logic [DW-1:0] nx_o,
    output logic [DW-1:0] ny_o,
    output logic [DW-1:0] nf_o,
    output logic          commit_o,
    output logic          hsync_n_o,
    output logic          vsync_n_o
);
    localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_VISV  = HW'(H_VIS);
    localparam logic [HW-1:0] HS_BEG  = HW'(H_VIS + H_FP);
    localparam logic [HW-1:0] HS_END  = HW'(H_VIS + H_FP + H_SYNC);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_PRE   = VW'(V_TOTAL - 2);
    localparam logic [VW-1:0] V_VISV  = VW'(V_VIS);
    localparam logic [VW-1:0] VS_BEG  = VW'(V_VIS + V_FP);
    localparam logic [VW-1:0] VS_END  = VW'(V_VIS + V_FP + V_SYNC);
    localparam logic [SW-1:0] S_LAST  = SW'(CELL - 1);
    localparam logic [DW-1:0] HC_LAST = DW'(H_TOTAL / CELL - 1);
    localparam logic [DW-1:0] HVC     = DW'(H_VIS / CELL);

    logic [HW-1:0] hcnt_q;
    logic [VW-1:0] vcnt_q;
    logic [SW-1:0] hsub_q, vsub_q;
    logic [DW-1:0] hcell_q, vrow_q, frame_q;
    logic          last_cell, last_line;
    logic [VW-1:0] nline;

    assign last_cell = (hcell_q == HC_LAST);
    assign last_line = (vcnt_q == V_LAST);

    // Advance pixel, cell, line, row and frame counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q  <= '0;
            vcnt_q  <= '0;
            hsub_q  <= '0;
            vsub_q  <= '0;
            hcell_q <= '0;
            vrow_q  <= '0;
            frame_q <= '0;
        end else begin
            hcnt_q <= (hcnt_q == H_LAST) ? '0 : hcnt_q + HW'(1);
            hsub_q <= (hsub_q == S_LAST) ? '0 : hsub_q + SW'(1);
            if (hsub_q == S_LAST)
                hcell_q <= last_cell ? '0 : hcell_q + DW'(1);
            if (hcnt_q == H_LAST) begin
                if (last_line) begin
                    vcnt_q  <= '0;
                    vsub_q  <= '0;
                    vrow_q  <= '0;
                    frame_q <= frame_q + DW'(1);
                end else begin
                    vcnt_q <= vcnt_q + VW'(1);
                    if (vsub_q == S_LAST) begin
                        vsub_q <= '0;
                        vrow_q <= vrow_q + DW'(1);
                    end else begin
                        vsub_q <= vsub_q + SW'(1);
                    end
                end
            end
        end
    end

    // Coordinates of the cell whose program runs during the current cell.
    always_comb begin
        nx_o  = last_cell ? '0 : hcell_q + DW'(1);
        nline = vcnt_q;
        ny_o  = vrow_q;
        nf_o  = frame_q;
        if (last_cell) begin
            if (last_line) begin
                nline = '0;
                ny_o  = '0;
                nf_o  = frame_q + DW'(1);
            end else begin
                nline = vcnt_q + VW'(1);
                ny_o  = (vsub_q == S_LAST) ? vrow_q + DW'(1) : vrow_q;
            end
        end
    end

    assign vis_next_o  = (nx_o < HVC) && (nline < V_VISV);
    assign vis_now_o   = (hcnt_q < H_VISV) && (vcnt_q < V_VISV);
    assign step_o      = hsub_q;
    assign step_last_o = (hsub_q == S_LAST);
    assign commit_o    = (hcnt_q == H_LAST) && (vcnt_q == V_PRE);
    assign hsync_n_o   = !((hcnt_q >= HS_BEG) && (hcnt_q < HS_END));
    assign vsync_n_o   = !((vcnt_q >= VS_BEG) && (vcnt_q < VS_END));

    AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n_o |-> !vis_now_o);  // R1
    AST_VSYNC_ON_CELL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n_o) |-> (hsub_q == '0));  // R2
endmodule

// File: rtl/shader_progmem.sv
// Program storage with an SPI write port. The SPI pins are brought into
// the pixel clock domain by two-stage synchronisers, so the serial clock
// must be well below a quarter of the pixel clock. Received bytes fill a
// shadow copy; the shadow is copied to the running program on commit_i
// when a transfer has finished and chip select is idle.
module shader_progmem #(
    parameter int PROG_LEN = 10,
    localparam int SW      = $clog2(PROG_LEN),
    localparam int AW      = $clog2(PROG_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sclk,
    input  logic          spi_mosi,
    input  logic          spi_cs_n,
    input  logic          commit_i,
    input  logic [SW-1:0] step_i,
    output logic [7:0]    instr_o
);
    localparam logic [AW-1:0] A_END = AW'(PROG_LEN);

    logic [1:0] sclk_sy, mosi_sy, cs_sy;
    logic       sclk_p, cs_p;
    logic [2:0] bit_q;
    logic [6:0] shr_q;
    logic [AW-1:0] addr_q;
    logic       pend_q;
    logic [PROG_LEN-1:0][7:0] sh_q, act_q;
    logic       sclk_rise, cs_idle, cs_end;

    assign cs_idle   = cs_sy[1];
    assign sclk_rise = sclk_sy[1] && !sclk_p && !cs_idle;
    assign cs_end    = cs_idle && !cs_p;

    // Synchronise the SPI pins and keep previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sy <= '0;
            mosi_sy <= '0;
            cs_sy   <= 2'b11;
            sclk_p  <= 1'b0;
            cs_p    <= 1'b1;
        end else begin
            sclk_sy <= {sclk_sy[0], spi_sclk};
            mosi_sy <= {mosi_sy[0], spi_mosi};
            cs_sy   <= {cs_sy[0], spi_cs_n};
            sclk_p  <= sclk_sy[1];
            cs_p    <= cs_sy[1];
        end
    end

    // Shift in bits MSB first and write each whole byte to the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            shr_q  <= '0;
            addr_q <= '0;
            sh_q   <= '0;
        end else if (cs_idle) begin
            bit_q  <= '0;
            addr_q <= '0;
        end else if (sclk_rise) begin
            shr_q <= {shr_q[5:0], mosi_sy[1]};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7 && addr_q < A_END) begin
                sh_q[SW'(addr_q)] <= {shr_q, mosi_sy[1]};
                addr_q            <= addr_q + AW'(1);
            end
        end
    end

    // Mark a finished transfer and copy the shadow at the frame commit point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            act_q  <= '0;
        end else if (commit_i && pend_q && cs_idle) begin
            pend_q <= 1'b0;
            act_q  <= sh_q;
        end else if (cs_end) begin
            pend_q <= 1'b1;
        end
    end

    assign instr_o = act_q[step_i];

    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= A_END);  // R9
    AST_SWAP_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(act_q));  // R10
endmodule

// File: rtl/shader_core.sv
// Accumulator datapath executing one instruction per clock. Step 0 of
// every cell starts from a clean state (accumulator, colour and scratch
// registers read as zero); col_o is the colour after the current step.
module shader_core #(
    parameter int CELL = 10,
    localparam int DW  = shader_pkg::DW,
    localparam int CW  = shader_pkg::CW,
    localparam int SW  = $clog2(CELL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] step_i,
    input  logic [7:0]    instr_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic [DW-1:0] f_i,
    output logic [CW-1:0] col_o
);
    import shader_pkg::*;

    logic [DW-1:0]            acc_q, a_eff, a_new, rd;
    logic [CW-1:0]            col_q, c_eff;
    logic [NGPR-1:0][DW-1:0]  gpr_q;
    logic [NGPR-1:0]          gval_q, v_eff;
    logic                     first, wr;
    op_e                      op;
    logic [3:0]               arg;
    logic [DW-1:0]            imm;

    assign first = (step_i == '0);
    assign a_eff = first ? '0 : acc_q;
    assign c_eff = first ? '0 : col_q;
    assign v_eff = first ? '0 : gval_q;
    assign op    = op_e'(instr_i[7:4]);
    assign arg   = instr_i[3:0];
    assign imm   = {{(DW-4){1'b0}}, arg};

    // Operand read: scratch registers, then the read-only coordinates.
    always_comb begin
        rd = '0;
        if (arg < 4'(NGPR))
            rd = v_eff[arg[2:0]] ? gpr_q[arg[2:0]] : '0;
        else if (arg == 4'(REG_X))
            rd = x_i;
        else if (arg == 4'(REG_Y))
            rd = y_i;
        else if (arg == 4'(REG_F))
            rd = f_i;
    end

    // Decode and evaluate the current instruction.
    always_comb begin
        a_new = a_eff;
        col_o = c_eff;
        wr    = 1'b0;
        case (op)
            OP_LDI:  a_new = imm;
            OP_LD:   a_new = rd;
            OP_ST:   wr    = (arg < 4'(NGPR));
            OP_ADD:  a_new = a_eff + rd;
            OP_SUB:  a_new = a_eff - rd;
            OP_AND:  a_new = a_eff & rd;
            OP_OR:   a_new = a_eff | rd;
            OP_XOR:  a_new = a_eff ^ rd;
            OP_SHL:  a_new = a_eff << arg;
            OP_SHR:  a_new = a_eff >> arg;
            OP_COL:  col_o = a_eff[CW-1:0];
            OP_ADDI: a_new = a_eff + imm;
            default: a_new = a_eff;
        endcase
    end

    // Commit accumulator, colour and register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            col_q  <= '0;
            gval_q <= '0;
            gpr_q  <= '0;
        end else begin
            acc_q  <= a_new;
            col_q  <= col_o;
            gval_q <= v_eff;
            if (wr) begin
                gpr_q[arg[2:0]]  <= a_eff;
                gval_q[arg[2:0]] <= 1'b1;
            end
        end
    end

    AST_FIRST_STEP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (first && op != OP_COL) |-> (col_o == '0));  // R7
endmodule

// File: rtl/pixel_shader_unit.sv
// Top of the per-pixel shader: timing, program store and datapath. The
// colour computed during one cell is registered at the cell's last step
// and shown for the whole following cell; blanking forces black.
module pixel_shader_unit #(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int CELL   = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    input  logic       spi_cs_n,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic [5:0] rgb
);
    localparam int DW = shader_pkg::DW;
    localparam int CW = shader_pkg::CW;
    localparam int SW = $clog2(CELL);

    logic [SW-1:0] step;
    logic          step_last, vis_now, vis_next, commit;
    logic [DW-1:0] nx, ny, nf;
    logic [7:0]    instr;
    logic [CW-1:0] col;

    shader_timing #(
        .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .CELL(CELL)
    ) u_tim (
        .clk(clk), .rst_n(rst_n), .step_o(step), .step_last_o(step_last),
        .vis_now_o(vis_now), .vis_next_o(vis_next), .nx_o(nx), .ny_o(ny),
        .nf_o(nf), .commit_o(commit), .hsync_n_o(hsync_n), .vsync_n_o(vsync_n)
    );

    shader_progmem #(.PROG_LEN(CELL)) u_prog (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .commit_i(commit), .step_i(step), .instr_o(instr)
    );

    shader_core #(.CELL(CELL)) u_core (
        .clk(clk), .rst_n(rst_n), .step_i(step), .instr_i(instr),
        .x_i(nx), .y_i(ny), .f_i(nf), .col_o(col)
    );

    // Latch the finished colour for the next cell, black when off screen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rgb <= '0;
        else if (step_last)
            rgb <= vis_next ? col : '0;
    end

    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !vis_now |-> (rgb == '0));  // R3
    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (step != '0) |-> $stable(rgb));  // R4
endmodule

// File: tb/sim_pixel_shader_unit.sv
module sim_pixel_shader_unit;
    localparam int HV = 40, HF = 2, HS = 4, HB = 4;
    localparam int VV = 20, VF = 1, VS = 2, VB = 1;
    localparam int CL = 10;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int FT = HT * VT;
    localparam int NF = 7;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic hsync_n, vsync_n;
    logic [5:0] rgb;

    int errors = 0, checks = 0;
    int n = 0;
    bit done = 0;
    logic [7:0] bsh [10];
    logic [7:0] bact [10];
    logic [7:0] xfer [16];
    bit pend = 0;

    always #2.5 clk = ~clk;

    pixel_shader_unit #(
        .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB), .CELL(CL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_cs_n(cs_n), .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, n, act, exp);
        end
    endtask

    // Reference shading from the written instruction semantics (R5, R6, R7).
    function automatic logic [5:0] shade(input int x, input int y, input int f);
        logic [7:0] a, v;
        logic [7:0] r [8];
        logic [5:0] c;
        a = 0; c = 0;
        for (int k = 0; k < 8; k++) r[k] = 0;
        for (int i = 0; i < 10; i++) begin
            int op, ag;
            op = bact[i][7:4];
            ag = bact[i][3:0];
            if (ag < 8) v = r[ag];
            else if (ag == 8) v = 8'(x);
            else if (ag == 9) v = 8'(y);
            else if (ag == 10) v = 8'(f % 256);
            else v = 0;
            case (op)
                0: a = 8'(ag);
                1: a = v;
                2: if (ag < 8) r[ag] = a;
                3: a = a + v;
                4: a = a - v;
                5: a = a & v;
                6: a = a | v;
                7: a = a ^ v;
                8: a = a << ag;
                9: a = a >> ag;
                10: c = a[5:0];
                11: a = a + 8'(ag);
                default: ;
            endcase
        end
        return c;
    endfunction

    task automatic spi_bit(input logic b);
        mosi = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    // Send nb whole bytes of xfer[] plus extra bits of an unfinished byte (R8, R9).
    task automatic spi_send(input int nb, input int extra);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nb; i++)
            for (int b = 7; b >= 0; b--) spi_bit(xfer[i][b]);
        for (int b = 0; b < extra; b++) spi_bit(1'b1);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        for (int i = 0; i < nb && i < 10; i++) bsh[i] = xfer[i];
        pend = 1;
    endtask

    task automatic wait_frame(input int k);
        while (n < k * FT + 5) @(negedge clk);
    endtask

    task automatic monitor();
        for (int i = 0; i < NF * FT; i++) begin
            int h, v, f, e;
            n = i;
            h = i % HT;
            v = (i / HT) % VT;
            f = i / FT;
            if (h == 0 && v == 0 && pend) begin  // R10 swap at frame start
                for (int k = 0; k < 10; k++) bact[k] = bsh[k];
                pend = 0;
            end
            chk("R1", int'(hsync_n), (h >= HV + HF && h < HV + HF + HS) ? 0 : 1);
            chk("R2", int'(vsync_n), (v >= VV + VF && v < VV + VF + VS) ? 0 : 1);
            if (h < HV && v < VV) begin
                e = shade(h / CL, v / CL, f);
                chk("R4", int'(rgb), e);  // also R5 R6 R7 R8 R9 R10 R11
            end else begin
                chk("R3", int'(rgb), 0);
            end
            @(negedge clk);
        end
    endtask

    task automatic stimulus();
        // P1: full program using coordinates, frame count and ignored writes (R5, R6)
        xfer[0] = 8'h18; xfer[1] = 8'h20; xfer[2] = 8'h19; xfer[3] = 8'h82;
        xfer[4] = 8'h70; xfer[5] = 8'h3A; xfer[6] = 8'h2C; xfer[7] = 8'h6C;
        xfer[8] = 8'hA0; xfer[9] = 8'h91;
        wait_frame(1);
        spi_send(10, 0);
        // P2: four bytes only, rest of slots kept (R8, R7 unwritten r0 reads 0)
        xfer[0] = 8'h0F; xfer[1] = 8'h48; xfer[2] = 8'h21; xfer[3] = 8'hB3;
        wait_frame(2);
        spi_send(4, 0);
        // P3: twelve bytes, last two must be dropped (R9); slot 9 reserved opcode
        xfer[0] = 8'h19; xfer[1] = 8'h23; xfer[2] = 8'h07; xfer[3] = 8'h53;
        xfer[4] = 8'h84; xfer[5] = 8'h24; xfer[6] = 8'h18; xfer[7] = 8'h44;
        xfer[8] = 8'hA0; xfer[9] = 8'hC5; xfer[10] = 8'hA0; xfer[11] = 8'h00;
        wait_frame(3);
        spi_send(12, 0);
        // P4: three bytes then an unfinished byte (R9); two colour sets (R7)
        xfer[0] = 8'h0A; xfer[1] = 8'hA0; xfer[2] = 8'h1A;
        wait_frame(4);
        spi_send(3, 5);
    endtask

    initial begin
        for (int k = 0; k < 10; k++) begin bsh[k] = 0; bact[k] = 0; end
        repeat (4) @(negedge clk);
        chk("R11", int'(hsync_n), 1);
        chk("R11", int'(vsync_n), 1);
        chk("R11", int'(rgb), 0);
        rst_n = 1'b1;
        fork
            monitor();
            stimulus();
        join
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule